// File: doc/BRIEF.md
# Debug Control Port for a Pipelined Core

This block sits beside a processor core and gives a debugger a small register window into it. The debugger issues commands made of a write flag, an 8-bit address and a 32-bit data word. Each accepted command produces a response one cycle later. Through this window the debugger can halt and release the core, hold it in reset, step it one instruction at a time, feed it instructions while it is halted, and read back the most recent value the core wrote to its register file.

The control word at address 0x00 has separate set and clear bits for reset and halt, so one write never has to read and modify the word first. A breakpoint reported by the core stops it and leaves a sticky flag that tells the debugger why it stopped. Address 0x04 has two meanings. A read returns the last register-file write value. A write passes the data word to the pipeline as an instruction, and the command is stalled until the pipeline takes it. The debug logic has its own reset input. Its reset request drives both the core reset and a system reset output, so the debugger can restart the core and the peripherals.

Top module: `dbg_ctrl`

## Requirements
- R1: Every accepted command (`cmd_valid` and `cmd_ready` both high at a clock edge) raises `rsp_valid` for exactly the following cycle. No other cycle has `rsp_valid` high. A write response carries zero data, and so does a read of any address other than 0x00 or 0x04.
- R2: A read of 0x00 returns reset request in bit 0, halt request in bit 1, `core_busy` (sampled at acceptance) in bit 2, breakpoint flag in bit 3 and step request in bit 4, with zeros in all other bits.
- R3: A write to 0x00 sets reset request when data bit 16 is 1, sets halt request when bit 17 is 1 and sets step request when bit 4 is 1. A 0 in any of these bits leaves the corresponding request unchanged.
- R4: In a write to 0x00, bit 24 clears reset request, and bit 25 clears both halt request and the breakpoint flag. A clear bit wins over a set bit in the same write.
- R5: Each cycle in which `rf_wr_en` is high captures `rf_wr_data`. A read of 0x04 returns the last captured value, and cycles with `rf_wr_en` low leave it unchanged.
- R6: A `core_bkpt` pulse sets both halt request and the breakpoint flag on the next edge. This wins over a clear written in the same cycle.
- R7: A write to 0x04 raises `inj_valid` only while `core_halt` is high. When the core is not halted, the write completes at once and nothing is injected.
- R8: While an injection is pending, `inj_instr` equals `cmd_wdata` and `cmd_ready` equals `inj_ready`. Reads and writes to any other address are never stalled.
- R9: If step request and halt request are both set, `core_halt` goes low one edge later. It stays low until a `core_retire` pulse, and it is high again on the edge after that pulse, with step request cleared. A step request made while the core is running waits until halt is set.
- R10: `core_reset` and `sys_reset_out` follow the reset request. `dbg_rst` clears every request, the flag, the step state and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst | input | 1 | Synchronous active-high reset of the debug logic only |
| cmd_valid | input | 1 | Command present |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| rsp_valid | output | 1 | Response for the command accepted last cycle |
| rsp_data | output | 32 | Read data |
| core_busy | input | 1 | Pipeline holds instructions in flight |
| core_retire | input | 1 | One instruction completed this cycle |
| core_bkpt | input | 1 | Breakpoint executed this cycle |
| rf_wr_en | input | 1 | Register file written this cycle |
| rf_wr_data | input | 32 | Value written to the register file |
| core_halt | output | 1 | Halt request to the core |
| core_reset | output | 1 | Reset request to the core |
| sys_reset_out | output | 1 | Reset request to the rest of the system |
| inj_valid | output | 1 | Instruction offered to the pipeline |
| inj_instr | output | 32 | Instruction word offered |
| inj_ready | input | 1 | Pipeline takes the offered instruction |

## Verification
A wrong set/clear priority or a wrong bit position shows up at `core_halt`, `core_reset` and the status word on the response after the next read, which is two cycles after the faulty write. A step engine that releases the core too early, too late or for too long is visible on `core_halt` cycle by cycle around the retire pulse. An injection handshake fault shows as a response that arrives while `inj_ready` is still low, or as `inj_valid` rising while the core is running.

// File: rtl/dbg_ctrl.sv
module dbg_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h00,
  parameter logic [AW-1:0] DATA_ADDR = 8'h04
) (
  input  logic          clk,
  input  logic          dbg_rst,
  input  logic          cmd_valid,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          core_busy,
  input  logic          core_retire,
  input  logic          core_bkpt,
  input  logic          rf_wr_en,
  input  logic [DW-1:0] rf_wr_data,
  output logic          core_halt,
  output logic          core_reset,
  output logic          sys_reset_out,
  output logic          inj_valid,
  output logic [DW-1:0] inj_instr,
  input  logic          inj_ready
);
  localparam int STEP_BIT = 4;
  localparam int RST_SET  = 16;
  localparam int HLT_SET  = 17;
  localparam int RST_CLR  = 24;
  localparam int HLT_CLR  = 25;

  logic          reset_req, halt_req, bkpt_flag, step_req, step_run;
  logic [DW-1:0] last_rf;
  logic [DW-1:0] rd_val;
  logic          acc, wr_ctrl;

  assign acc       = cmd_valid && cmd_ready;
  assign wr_ctrl   = acc && cmd_wr && (cmd_addr == CTRL_ADDR);
  assign core_halt = halt_req && !step_run;
  assign inj_valid = cmd_valid && cmd_wr && (cmd_addr == DATA_ADDR) && core_halt;
  assign inj_instr = cmd_wdata;
  assign cmd_ready = !inj_valid || inj_ready;
  assign core_reset    = reset_req;
  assign sys_reset_out = reset_req;

  always_comb begin
    rd_val = '0;
    if (cmd_addr == CTRL_ADDR)
      rd_val[4:0] = {step_req, bkpt_flag, core_busy, halt_req, reset_req};
    else if (cmd_addr == DATA_ADDR)
      rd_val = last_rf;
  end

  always_ff @(posedge clk) begin
    if (dbg_rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_data  <= (acc && !cmd_wr) ? rd_val : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (dbg_rst) last_rf <= '0;
    else if (rf_wr_en) last_rf <= rf_wr_data;
  end

  always_ff @(posedge clk) begin
    if (dbg_rst) begin
      reset_req <= 1'b0;
      halt_req  <= 1'b0;
      bkpt_flag <= 1'b0;
      step_req  <= 1'b0;
      step_run  <= 1'b0;
    end else begin
      if (step_run) begin
        if (core_retire) begin
          step_run <= 1'b0;
          step_req <= 1'b0;
        end
      end else if (step_req && halt_req) begin
        step_run <= 1'b1;
      end
      if (wr_ctrl) begin
        if (cmd_wdata[STEP_BIT]) step_req  <= 1'b1;
        if (cmd_wdata[RST_SET])  reset_req <= 1'b1;
        if (cmd_wdata[RST_CLR])  reset_req <= 1'b0;
        if (cmd_wdata[HLT_SET])  halt_req  <= 1'b1;
        if (cmd_wdata[HLT_CLR]) begin
          halt_req  <= 1'b0;
          bkpt_flag <= 1'b0;
        end
      end
      if (core_bkpt) begin
        halt_req  <= 1'b1;
        bkpt_flag <= 1'b1;
      end
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (dbg_rst)
    acc |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (dbg_rst)
    !acc |=> !rsp_valid); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (dbg_rst)
    (wr_ctrl && cmd_wdata[HLT_CLR] && !core_bkpt) |=> (!halt_req && !bkpt_flag)); // R4
  AST_BKPT_HALTS: assert property (@(posedge clk) disable iff (dbg_rst)
    core_bkpt |=> (halt_req && bkpt_flag)); // R6
  AST_INJ_WHILE_HALTED: assert property (@(posedge clk) disable iff (dbg_rst)
    inj_valid |-> halt_req); // R7
  AST_ONLY_INJ_STALLS: assert property (@(posedge clk) disable iff (dbg_rst)
    (cmd_valid && !cmd_ready) |-> (cmd_wr && cmd_addr == DATA_ADDR)); // R8
  AST_STEP_ENDS: assert property (@(posedge clk) disable iff (dbg_rst)
    (step_run && core_retire && !wr_ctrl) |=> (!step_run && !step_req)); // R9
  AST_STEP_NEEDS_HALT: assert property (@(posedge clk) disable iff (dbg_rst)
    $rose(step_run) |-> $past(halt_req)); // R9
endmodule

// File: tb/dbg_ctrl_tb.sv
module dbg_ctrl_tb;
  logic        clk = 0;
  logic        dbg_rst = 1;
  logic        cmd_valid = 0, cmd_wr = 0;
  logic [7:0]  cmd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        core_busy = 0, core_retire = 0, core_bkpt = 0, rf_wr_en = 0;
  logic [31:0] rf_wr_data = 0;
  logic        core_halt, core_reset, sys_reset_out, inj_valid;
  logic [31:0] inj_instr;
  logic        inj_ready = 1;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dbg_ctrl u_dut (
    .clk(clk), .dbg_rst(dbg_rst), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .core_busy(core_busy),
    .core_retire(core_retire), .core_bkpt(core_bkpt), .rf_wr_en(rf_wr_en),
    .rf_wr_data(rf_wr_data), .core_halt(core_halt), .core_reset(core_reset),
    .sys_reset_out(sys_reset_out), .inj_valid(inj_valid), .inj_instr(inj_instr),
    .inj_ready(inj_ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    cmd_valid = 1; cmd_wr = wr; cmd_addr = a; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 0; cmd_wr = 0;
    r = rsp_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    dbg_rst = 0;
    @(negedge clk);
    chk("R10 reset halt", {31'b0, core_halt}, 0);
    chk("R10 reset core_reset", {31'b0, core_reset}, 0);
    chk("R10 reset sys_reset_out", {31'b0, sys_reset_out}, 0);
    cmd(0, 8'h00, 0, rd);
    chk("R2 reset status", rd, 0);

    // R3 R4 sweep over start state and all set/clear combinations
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 16; c++) begin
        logic er, eh;
        cmd(1, 8'h00, 32'h0300_0000, rd);
        cmd(1, 8'h00, {14'b0, s[1], s[0], 16'b0}, rd);
        cmd(1, 8'h00, {6'b0, c[3], c[2], 6'b0, c[1], c[0], 16'b0}, rd);
        chk("R1 write rsp data", rd, 0);
        er = c[2] ? 1'b0 : (c[0] | s[0]);
        eh = c[3] ? 1'b0 : (c[1] | s[1]);
        cmd(0, 8'h00, 0, rd);
        chk("R3/R4 status", rd, {30'b0, eh, er});
        chk("R10 reset outputs", {30'b0, sys_reset_out, core_reset}, {30'b0, er, er});
        chk("R3/R4 core_halt", {31'b0, core_halt}, {31'b0, eh});
      end
    cmd(1, 8'h00, 32'h0300_0000, rd);

    // R2 busy bit
    core_busy = 1;
    cmd(0, 8'h00, 0, rd);
    chk("R2 busy bit", rd, 32'h4);
    core_busy = 0;

    // R6 breakpoint
    @(negedge clk); core_bkpt = 1;
    @(negedge clk); core_bkpt = 0;
    chk("R6 bkpt halts", {31'b0, core_halt}, 1);
    cmd(0, 8'h00, 0, rd);
    chk("R6 status after bkpt", rd, 32'h0A);
    cmd(1, 8'h00, 32'h0200_0000, rd);
    cmd(0, 8'h00, 0, rd);
    chk("R4 bit25 clears halt and flag", rd, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_wr = 1; cmd_addr = 8'h00; cmd_wdata = 32'h0200_0000; core_bkpt = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_wr = 0; core_bkpt = 0;
    cmd(0, 8'h00, 0, rd);
    chk("R6 bkpt beats clear", rd, 32'h0A);
    cmd(1, 8'h00, 32'h0200_0000, rd);

    // R5 register-file readback
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'hA5C3_0000 ^ (i * 32'h0101_0137);
      @(negedge clk); rf_wr_en = 1; rf_wr_data = v;
      @(negedge clk); rf_wr_en = 0; rf_wr_data = ~v;
      @(negedge clk);
      cmd(0, 8'h04, 0, rd);
      chk("R5 last rf value", rd, v);
    end
    cmd(0, 8'h08, 0, rd);
    chk("R1 unmapped read zero", rd, 0);

    // R7 injection while running is dropped
    @(negedge clk);
    cmd_valid = 1; cmd_wr = 1; cmd_addr = 8'h04; cmd_wdata = 32'hDEAD_0013;
    #1;
    chk("R7 no inj when running", {31'b0, inj_valid}, 0);
    chk("R7 ready when running", {31'b0, cmd_ready}, 1);
    @(negedge clk); cmd_valid = 0; cmd_wr = 0;
    chk("R1 rsp after dropped write", {31'b0, rsp_valid}, 1);

    // R8 injection with hold-off while halted
    cmd(1, 8'h00, 32'h0002_0000, rd);
    inj_ready = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_wr = 1; cmd_addr = 8'h04; cmd_wdata = 32'h0040_0093;
    #1;
    chk("R7 inj when halted", {31'b0, inj_valid}, 1);
    chk("R8 inj word", inj_instr, 32'h0040_0093);
    chk("R8 ready held low", {31'b0, cmd_ready}, 0);
    repeat (3) @(negedge clk);
    chk("R1 no rsp while stalled", {31'b0, rsp_valid}, 0);
    chk("R8 still stalled", {31'b0, cmd_ready}, 0);
    inj_ready = 1;
    #1;
    chk("R8 ready follows inj_ready", {31'b0, cmd_ready}, 1);
    @(negedge clk); cmd_valid = 0; cmd_wr = 0;
    chk("R1 rsp after injection", {31'b0, rsp_valid}, 1);

    // R9 single step from halt
    @(negedge clk);
    cmd_valid = 1; cmd_wr = 1; cmd_addr = 8'h00; cmd_wdata = 32'h10;
    @(negedge clk); cmd_valid = 0; cmd_wr = 0;
    chk("R9 still halted at request", {31'b0, core_halt}, 1);
    @(negedge clk);
    chk("R9 released next edge", {31'b0, core_halt}, 0);
    cmd(0, 8'h00, 0, rd);
    chk("R9 status during step", rd, 32'h12);
    chk("R9 stays released", {31'b0, core_halt}, 0);
    core_retire = 1;
    @(negedge clk); core_retire = 0;
    chk("R9 halts after retire", {31'b0, core_halt}, 1);
    cmd(0, 8'h00, 0, rd);
    chk("R9 step cleared", rd, 32'h02);

    // R9 step pending while running
    cmd(1, 8'h00, 32'h0200_0010, rd);
    repeat (3) @(negedge clk);
    chk("R9 pending step no halt", {31'b0, core_halt}, 0);
    cmd(0, 8'h00, 0, rd);
    chk("R9 pending step status", rd, 32'h10);

    // R10 debug reset clears all
    cmd(1, 8'h00, 32'h0003_0000, rd);
    chk("R10 reset out asserted", {31'b0, sys_reset_out}, 1);
    @(negedge clk); dbg_rst = 1;
    @(negedge clk); dbg_rst = 0;
    chk("R10 dbg_rst clears reset", {30'b0, sys_reset_out, core_reset}, 0);
    chk("R10 dbg_rst clears halt", {31'b0, core_halt}, 0);
    cmd(0, 8'h00, 0, rd);
    chk("R10 status after dbg_rst", rd, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule